// File: doc/BRIEF.md
# Programmable Baud Tick Divider

This block divides a counting source down to a tick at sixteen times the wanted serial bit rate. The division ratio is a 16-bit value, so the divisor for a given rate is the source frequency over sixteen times the bit rate. Software sets the divisor one byte at a time through two 8-bit lanes: a low byte and a high byte. Every write to either lane restarts the down-counter on the following clock edge, so a new rate takes effect at once and never waits out a long count left over from the old one.

The counting source is either the system clock itself or an external baud clock. The external clock passes through a synchronizer in the system clock domain, and each rising edge is one counting step. A count-enable input gates both sources. The tick is one system clock wide, and a copy of it leaves the block as `baud_out` so that it can drive a receiver sampling input.

All pins are plain control and status pins. No data stream crosses the block's edge, so there is no valid/ready handshake.

Top module: `baud_divgen`

## Requirements
- R1: After reset both divisor lanes read 0 and `tick16` stays low, even while `cnt_en` is high.
- R2: A write with `cfg_wr` high and `cfg_sel` = 0 stores `cfg_wdata` in divisor bits 7:0. With `cfg_sel` = 1 it stores them in bits 15:8. `cfg_rdata` combinationally shows the lane picked by `cfg_sel`.
- R3: The counter loads the divisor D on the clock edge after a write edge, whatever count it held before. With the system source and `cnt_en` high, the first tick is high during cycle D+1 after the write edge and low before it.
- R4: For any D from 1 to 65535, ticks repeat every D counting steps. D = 1 gives a tick on every counting step.
- R5: When D > 1, each tick lasts exactly one clock cycle.
- R6: A divisor of 0 produces no tick.
- R7: While `cnt_en` is low, the counter holds its value and no tick occurs. Each gated cycle delays the next tick by one cycle.
- R8: With `src_ext` = 1, the counter takes one step per synchronized rising edge of `ext_baud_clk`, gated by `cnt_en`. Ticks are spaced D times the external clock period.
- R9: `baud_out` equals `tick16` in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr | input | 1 | Divisor lane write strobe |
| cfg_sel | input | 1 | Lane select: 0 low byte, 1 high byte |
| cfg_wdata | input | 8 | Byte written to the selected lane |
| cfg_rdata | output | 8 | Contents of the selected lane |
| src_ext | input | 1 | 0: count system clock cycles, 1: count external clock edges |
| ext_baud_clk | input | 1 | External baud clock, asynchronous to clk |
| cnt_en | input | 1 | Counting enable for either source |
| tick16 | output | 1 | One-cycle pulse at 16x the baud rate |
| baud_out | output | 1 | Copy of the tick for a receiver clock input |

## Verification
Reloading takes one register stage and the terminal step takes another, so the first tick after the last write edge becomes visible after edge D+1. After that, ticks come every D edges. The bench counts falling edges from the write edge and compares `tick16` at each of them against this arithmetic, so a tick that comes one cycle early or late fails. Each gated cycle adds exactly one cycle to the due edge. In external mode the synchronizer latency is constant, so the bench measures the spacing between ticks rather than the absolute delay.

// File: rtl/baud_div_pkg.sv
package baud_div_pkg;
  localparam int unsigned DEF_DIV_W  = 16;
  localparam int unsigned DEF_BYTE_W = 8;
  localparam int unsigned DEF_SYNC   = 2;

  typedef enum logic {
    SRC_SYS = 1'b0,
    SRC_EXT = 1'b1
  } src_e;
endpackage

// File: rtl/baud_div_latch.sv
module baud_div_latch #(
  parameter int unsigned DIV_W  = 16,
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned NB    = DIV_W / BYTE_W,
  localparam int unsigned SEL_W = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [SEL_W-1:0]  sel,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  output logic [DIV_W-1:0]  div_val,
  output logic              load_req
);
  logic [BYTE_W-1:0] lane_q [NB];

  for (genvar i = 0; i < NB; i++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lane_q[i] <= '0;
      end else if (wr && (sel == SEL_W'(i))) begin
        lane_q[i] <= wdata;
      end
    end
    assign div_val[i*BYTE_W +: BYTE_W] = lane_q[i];
  end

  assign rdata = lane_q[sel];

  // reload request is raised for the edge following any lane write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_req <= 1'b0;
    end else begin
      load_req <= wr;
    end
  end
endmodule

// File: rtl/baud_div_src.sv
module baud_div_src
  import baud_div_pkg::*;
#(
  parameter int unsigned SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic src_ext,
  input  logic ext_clk,
  input  logic en,
  output logic step
);
  logic [SYNC-1:0] sync_q;
  logic            prev_q;
  logic            rise;
  src_e            mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC-2:0], ext_clk};
      prev_q <= sync_q[SYNC-1];
    end
  end

  assign rise = sync_q[SYNC-1] & ~prev_q;
  assign mode = src_e'(src_ext);

  always_comb begin
    unique case (mode)
      SRC_EXT: step = rise & en;
      default: step = en;
    endcase
  end
endmodule

// File: rtl/baud_div_cnt.sv
module baud_div_cnt #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_val,
  input  logic             load_req,
  input  logic             step,
  output logic [DIV_W-1:0] cnt_val,
  output logic             tick
);
  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  logic div_zero;
  assign div_zero = (div_val == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_val <= '0;
      tick    <= 1'b0;
    end else begin
      tick <= 1'b0;
      if (load_req) begin
        cnt_val <= div_val;
      end else if (div_zero) begin
        cnt_val <= '0;
      end else if (step) begin
        if (cnt_val <= ONE) begin
          cnt_val <= div_val;
          tick    <= 1'b1;
        end else begin
          cnt_val <= cnt_val - ONE;
        end
      end
    end
  end
endmodule

// File: rtl/baud_divgen.sv
module baud_divgen
  import baud_div_pkg::*;
#(
  parameter int unsigned DIV_W  = DEF_DIV_W,
  parameter int unsigned BYTE_W = DEF_BYTE_W,
  parameter int unsigned SYNC   = DEF_SYNC,
  localparam int unsigned NB    = DIV_W / BYTE_W,
  localparam int unsigned SEL_W = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic [BYTE_W-1:0] cfg_wdata,
  output logic [BYTE_W-1:0] cfg_rdata,
  input  logic              src_ext,
  input  logic              ext_baud_clk,
  input  logic              cnt_en,
  output logic              tick16,
  output logic              baud_out
);
  logic [DIV_W-1:0] div_val;
  logic [DIV_W-1:0] cnt_val;
  logic             load_req;
  logic             step;
  logic             tick_q;

  baud_div_latch #(.DIV_W(DIV_W), .BYTE_W(BYTE_W)) u_latch (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (cfg_wr),
    .sel      (cfg_sel),
    .wdata    (cfg_wdata),
    .rdata    (cfg_rdata),
    .div_val  (div_val),
    .load_req (load_req)
  );

  baud_div_src #(.SYNC(SYNC)) u_src (
    .clk     (clk),
    .rst_n   (rst_n),
    .src_ext (src_ext),
    .ext_clk (ext_baud_clk),
    .en      (cnt_en),
    .step    (step)
  );

  baud_div_cnt #(.DIV_W(DIV_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .div_val  (div_val),
    .load_req (load_req),
    .step     (step),
    .cnt_val  (cnt_val),
    .tick     (tick_q)
  );

  assign tick16   = tick_q;
  assign baud_out = tick_q;
endmodule

// File: rtl/baud_divgen_chk.sv
module baud_divgen_chk #(
  parameter int unsigned DIV_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_wr,
  input logic             load_req,
  input logic [DIV_W-1:0] div_val,
  input logic [DIV_W-1:0] cnt_val,
  input logic             step,
  input logic             tick
);
  AST_RELOAD_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr ##1 !cfg_wr) |=> (cnt_val == div_val)); // R3

  AST_SINGLE_CYCLE_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (div_val > DIV_W'(1)) && !$past(cfg_wr)) |=> !tick); // R5

  AST_ZERO_DIV_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (div_val == '0) |=> !tick); // R6

  AST_HOLD_WHEN_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !load_req && (div_val != '0)) |=> $stable(cnt_val)); // R7
endmodule

bind baud_divgen baud_divgen_chk #(.DIV_W(DIV_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cfg_wr   (cfg_wr),
  .load_req (load_req),
  .div_val  (div_val),
  .cnt_val  (cnt_val),
  .step     (step),
  .tick     (tick16)
);

// File: tb/baud_divgen_test.sv
`timescale 1ns/1ps
module baud_divgen_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [0:0] cfg_sel = 1'b0;
  logic [7:0] cfg_wdata = 8'h00;
  logic [7:0] cfg_rdata;
  logic       src_ext = 1'b0;
  logic       ext_baud_clk = 1'b0;
  logic       cnt_en = 1'b1;
  logic       tick16;
  logic       baud_out;

  int  n_run = 0;
  int  n_fail = 0;
  int  mirror_bad = 0;
  bit  ext_run = 1'b0;
  bit  finished = 1'b0;

  always #4 clk = ~clk;

  baud_divgen uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_wr       (cfg_wr),
    .cfg_sel      (cfg_sel),
    .cfg_wdata    (cfg_wdata),
    .cfg_rdata    (cfg_rdata),
    .src_ext      (src_ext),
    .ext_baud_clk (ext_baud_clk),
    .cnt_en       (cnt_en),
    .tick16       (tick16),
    .baud_out     (baud_out)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  task automatic wr_lane(input bit sel, input logic [7:0] data);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = data;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic set_div(input int d);
    wr_lane(1'b0, d[7:0]);
    wr_lane(1'b1, d[15:8]);
  endtask

  // first tick due after edge d+1 of the last write; then every d edges
  task automatic measure(input int d, input bit period);
    int bad_k = 0;
    int bad_v = 0;
    for (int k = 1; k <= d + 1; k++) begin
      @(negedge clk);
      if (tick16 !== (k == d + 1) && bad_k == 0) begin bad_k = k; bad_v = tick16; end
    end
    chk(bad_k == 0, $sformatf("R3 first tick D=%0d at edge", d), bad_k, d + 1);
    if (period) begin
      bad_k = 0;
      for (int k = 1; k <= d; k++) begin
        @(negedge clk);
        if (tick16 !== (k == d) && bad_k == 0) begin bad_k = k; bad_v = tick16; end
      end
      chk(bad_k == 0, $sformatf("R4/R5 period D=%0d mismatch at step", d), bad_k, d);
    end
  endtask

  task automatic quiet(input int n, input string req);
    int seen = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (tick16) seen++;
    end
    chk(seen == 0, req, seen, 0);
  endtask

  always @(negedge clk) if (baud_out !== tick16) mirror_bad++;

  initial begin : ext_gen
    int ph = 0;
    forever begin
      @(negedge clk);
      if (ext_run) begin
        ph++;
        if (ph == 4) begin ph = 0; ext_baud_clk = ~ext_baud_clk; end
      end
    end
  end

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin : main
    int t0;
    int gap;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    cfg_sel = 1'b0; @(negedge clk);
    chk(cfg_rdata == 8'h00, "R1 low lane after reset", cfg_rdata, 0);
    cfg_sel = 1'b1; @(negedge clk);
    chk(cfg_rdata == 8'h00, "R1 high lane after reset", cfg_rdata, 0);
    quiet(40, "R1 ticks after reset");

    // R2 lane write and readback
    wr_lane(1'b0, 8'hA5);
    wr_lane(1'b1, 8'h3C);
    cfg_sel = 1'b0; #1;
    chk(cfg_rdata == 8'hA5, "R2 low lane readback", cfg_rdata, 8'hA5);
    cfg_sel = 1'b1; #1;
    chk(cfg_rdata == 8'h3C, "R2 high lane readback", cfg_rdata, 8'h3C);

    // R3 R4 R5 sweep of divisors
    for (int d = 1; d <= 40; d++) begin
      set_div(d);
      measure(d, 1'b1);
    end
    set_div(255);  measure(255, 1'b1);
    set_div(256);  measure(256, 1'b1);
    set_div(4660); measure(4660, 1'b1);
    set_div(65535); measure(65535, 1'b0);

    // R3 reload in mid count
    set_div(20);
    repeat (5) @(negedge clk);
    wr_lane(1'b0, 8'd3);
    measure(3, 1'b1);

    // R7 enable gating delays the tick by the gated cycles
    set_div(5);
    begin
      int bad_k = 0;
      for (int k = 1; k <= 9; k++) begin
        @(negedge clk);
        if (k == 1) cnt_en = 1'b0;
        if (k == 4) cnt_en = 1'b1;
        if (tick16 !== (k == 9) && bad_k == 0) bad_k = k;
      end
      chk(bad_k == 0, "R7 gated count tick edge", bad_k, 9);
    end
    cnt_en = 1'b0;
    quiet(30, "R7 no tick while disabled");
    cnt_en = 1'b1;

    // R6 zero divisor stops ticks
    set_div(2);
    measure(2, 1'b1);
    set_div(0);
    quiet(60, "R6 ticks with divisor 0");

    // R8 external source, period 8 cycles, D=3 -> spacing 24
    src_ext = 1'b1;
    ext_run = 1'b1;
    set_div(3);
    t0 = 0;
    for (int k = 0; k < 200 && !tick16; k++) @(negedge clk);
    chk(tick16 === 1'b1, "R8 first external tick", tick16, 1);
    for (int r = 0; r < 3; r++) begin
      gap = 0;
      do begin @(negedge clk); gap++; end while (!tick16 && gap < 200);
      chk(gap == 24, "R8 external tick spacing", gap, 24);
    end
    cnt_en = 1'b0;
    quiet(100, "R8 external source gated by enable");
    cnt_en = 1'b1;
    ext_run = 1'b0;
    src_ext = 1'b0;

    chk(mirror_bad == 0, "R9 baud_out mirrors tick16", mirror_bad, 0);
    report();
  end
endmodule